// File: doc/BRIEF.md
# Predicated Vector Repeat Sequencer

This block runs one vector instruction across sixteen 16-bit lanes, several times in a row. A single `start` captures an instruction word: how many times to repeat, which lanes may write, whether the lanes update their flags, how the accumulator is handled and which scalar reduction to produce. The block then performs one repetition per clock until the count is used up. Each lane adds or subtracts its two operands. The result can be folded into a per-lane saturating accumulator. A predicate, tested against that lane's own zero, negative and carry flags, decides whether the lane writes back.

Every repetition produces a registered lane result vector and a lane write-enable mask. When a reduction is selected, it also produces a scalar value with its own N and Z flags. The scalar can be lane 0's value, the sum of the active lanes, or the index of the smallest or largest active lane. A pulse marks the last repetition. Operands are sampled from the operand ports on every repetition edge, so a producer can stream new data on each repetition or hold it steady.

Top module: `vec_rep_seq`

## Requirements
- R1: A `start` seen while idle latches the instruction. Results then appear on `res_vld` for consecutive cycles, the first one a cycle after the edge that sampled `start`. The number of repetitions is 2^`rep_code` for `rep_code` 0..6. For code 7 it is `rep_scalar`, and a value of 0 counts as one repetition.
- R2: `busy` is high from the edge that accepts `start` until the final repetition. `done` is high together with the final `res_vld` only. A `start` while busy is ignored and does not alter the running instruction.
- R3: `pred_sel` selects which lanes write: 0 always, 1 never, 2 zero flag set, 3 zero flag clear, 4 negative flag set, 5 negative flag clear, 6 carry flag set, 7 carry flag clear. The test uses the lane's flags as they stand before the current repetition. `lane_we` shows the active lanes, and it is all zero when `res_vld` is low.
- R4: With `sub_mode` 0 the raw lane value is a+b modulo 2^16, and with `sub_mode` 1 it is a-b modulo 2^16. The lane carry is bit 16 of the 17-bit unsigned sum, or the borrow of the 17-bit unsigned difference.
- R5: The flags of a lane change only when the lane is active and `set_flags` is 1. Zero is set when the written value equals 0, negative copies bit 15 of the written value, and carry is the R4 carry. In all other cases the flags hold.
- R6: With `acc_en`, the written value is the signed 16-bit saturating sum of the lane accumulator and the raw value (limits 0x7FFF and 0x8000). The accumulator takes that sum only in active lanes and holds in the others.
- R7: With `clr_acc`, every accumulator lane is zeroed before the first repetition is computed. Later repetitions of the same instruction do not clear it again.
- R8: `red_sel` selects the reduction. 1 gives lane 0's written value, sign-extended. 2 gives the signed sum of the active lanes' written values. 3 and 4 give the index of the minimum or maximum signed value among the active lanes, with ties going to the lowest lane and all ones (-1) when no lane is active. Codes 0, 5, 6 and 7 produce no scalar (`scal_vld` low).
- R9: `scal_n` and `scal_z` give the sign and the zero test of the latest reduced value. They change only on cycles where `scal_vld` is high.
- R10: After reset, `busy`, `res_vld`, `done`, `scal_vld`, `lane_we`, all lane flags, `scal_n`, `scal_z` and every accumulator lane are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an instruction when idle |
| rep_code | input | 3 | Repeat count select |
| rep_scalar | input | CNT_W | Count used when rep_code is 7 |
| pred_sel | input | 3 | Lane predicate select |
| set_flags | input | 1 | Active lanes update their flags |
| clr_acc | input | 1 | Clear accumulator on first repetition |
| acc_en | input | 1 | Fold results into the accumulator |
| sub_mode | input | 1 | 0 add, 1 subtract |
| red_sel | input | 3 | Scalar reduction select |
| opa | input | LANES*DW | Lane operand A, lane i at bits i*DW |
| opb | input | LANES*DW | Lane operand B |
| busy | output | 1 | Instruction in progress |
| res_vld | output | 1 | A repetition result is present |
| lane_we | output | LANES | Per-lane write enable |
| lane_res | output | LANES*DW | Per-lane written value |
| flag_z | output | LANES | Lane zero flags |
| flag_n | output | LANES | Lane negative flags |
| flag_c | output | LANES | Lane carry flags |
| scal_vld | output | 1 | Scalar result present |
| scal_res | output | SW | Scalar reduction result |
| scal_n | output | 1 | Scalar negative flag |
| scal_z | output | 1 | Scalar zero flag |
| done | output | 1 | Final repetition completed |

## Verification
The assertions check the sequencing on every cycle. A launch from idle always leads to a busy phase, the remaining count never reaches zero while busy, and the latched instruction holds until the last repetition. `done` only appears with a result after busy has dropped. Lane flags hold whenever no active lane is setting them, and an index reduction always gives either -1 or a legal lane number, with -1 exactly when no lane writes. The numeric side can only be shown by the bench's scenarios: saturation limits, predicates that feed on flags changed by earlier repetitions, an accumulator that survives into the next instruction without being cleared again, tie-breaking, the zero scalar count, and a start pulse in the middle of a run.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

  localparam logic [2:0] PR_ALWAYS = 3'd0;
  localparam logic [2:0] PR_NEVER  = 3'd1;
  localparam logic [2:0] PR_IFZ    = 3'd2;
  localparam logic [2:0] PR_IFNZ   = 3'd3;
  localparam logic [2:0] PR_IFN    = 3'd4;
  localparam logic [2:0] PR_IFNN   = 3'd5;
  localparam logic [2:0] PR_IFC    = 3'd6;
  localparam logic [2:0] PR_IFNC   = 3'd7;

  localparam logic [2:0] RD_NONE  = 3'd0;
  localparam logic [2:0] RD_LANE0 = 3'd1;
  localparam logic [2:0] RD_SUM   = 3'd2;
  localparam logic [2:0] RD_IMIN  = 3'd3;
  localparam logic [2:0] RD_IMAX  = 3'd4;

  localparam logic [2:0] RC_SCALAR = 3'd7;

  typedef struct packed {
    logic [2:0] pred;
    logic       setf;
    logic       clr;
    logic       acc;
    logic       sub;
    logic [2:0] red;
  } cfg_t;

endpackage

// File: rtl/vrs_ctrl.sv
module vrs_ctrl
  import vrs_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int RC_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       rep_code,
  input  logic [CNT_W-1:0] rep_scalar,
  input  cfg_t             cfg_in,
  output logic             busy,
  output logic             first,
  output logic             last,
  output cfg_t             cfg_q
);

  logic [RC_W-1:0] left_q;
  logic [RC_W-1:0] cnt_c;

  always_comb begin
    if (rep_code == RC_SCALAR) begin
      cnt_c = (rep_scalar == '0) ? RC_W'(1) : RC_W'(rep_scalar);
    end else begin
      cnt_c = RC_W'(1) << rep_code;
    end
  end

  assign last = busy && (left_q == RC_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      first  <= 1'b0;
      left_q <= '0;
      cfg_q  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        first  <= 1'b1;
        left_q <= cnt_c;
        cfg_q  <= cfg_in;
      end
    end else begin
      first  <= 1'b0;
      left_q <= left_q - RC_W'(1);
      if (left_q == RC_W'(1)) busy <= 1'b0;
    end
  end

  AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> (busy && first)); // R1
  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (rst) busy |-> (left_q != '0)); // R1
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst) (busy && !last) |=> $stable(cfg_q)); // R2

endmodule

// File: rtl/vrs_lane.sv
module vrs_lane
  import vrs_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          first,
  input  logic [2:0]    pred,
  input  logic          setf,
  input  logic          clr,
  input  logic          acc_en,
  input  logic          sub,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          act,
  output logic          fz,
  output logic          fn,
  output logic          fc
);

  localparam logic [DW-1:0] SAT_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SAT_NEG = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] acc_q;
  logic [DW:0]   raw;
  logic [DW-1:0] base;
  logic [DW:0]   sum;
  logic [DW-1:0] sat;

  always_comb begin
    if (sub) raw = {1'b0, a} - {1'b0, b};
    else     raw = {1'b0, a} + {1'b0, b};
  end

  always_comb begin
    unique case (pred)
      PR_ALWAYS: act = 1'b1;
      PR_NEVER:  act = 1'b0;
      PR_IFZ:    act = fz;
      PR_IFNZ:   act = !fz;
      PR_IFN:    act = fn;
      PR_IFNN:   act = !fn;
      PR_IFC:    act = fc;
      default:   act = !fc;
    endcase
  end

  assign base = (first && clr) ? '0 : acc_q;
  assign sum  = {base[DW-1], base} + {raw[DW-1], raw[DW-1:0]};

  always_comb begin
    if (sum[DW] != sum[DW-1]) sat = sum[DW] ? SAT_NEG : SAT_POS;
    else                      sat = sum[DW-1:0];
  end

  assign res = acc_en ? sat : raw[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      fz    <= 1'b0;
      fn    <= 1'b0;
      fc    <= 1'b0;
    end else if (step) begin
      acc_q <= (act && acc_en) ? sat : base;
      if (act && setf) begin
        fz <= (res == '0);
        fn <= res[DW-1];
        fc <= raw[DW];
      end
    end
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst) !(step && act && setf) |=> $stable({fz, fn, fc})); // R5

endmodule

// File: rtl/vrs_reduce.sv
module vrs_reduce
  import vrs_pkg::*;
#(
  parameter int LANES = 16,
  parameter int DW    = 16,
  parameter int SW    = 32
) (
  input  logic [LANES*DW-1:0] res,
  input  logic [LANES-1:0]    act,
  input  logic [2:0]          sel,
  output logic [SW-1:0]       val,
  output logic                vld
);

  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [SW-1:0] sum;
  logic [IW-1:0] lo_idx, hi_idx;
  logic [DW-1:0] lo_val, hi_val;
  logic          any;

  always_comb begin
    sum    = '0;
    any    = 1'b0;
    lo_idx = '0;
    hi_idx = '0;
    lo_val = '0;
    hi_val = '0;
    for (int i = 0; i < LANES; i++) begin
      if (act[i]) begin
        sum = sum + {{(SW-DW){res[i*DW+DW-1]}}, res[i*DW +: DW]};
        if (!any || ($signed(res[i*DW +: DW]) < $signed(lo_val))) begin
          lo_idx = IW'(i);
          lo_val = res[i*DW +: DW];
        end
        if (!any || ($signed(res[i*DW +: DW]) > $signed(hi_val))) begin
          hi_idx = IW'(i);
          hi_val = res[i*DW +: DW];
        end
        any = 1'b1;
      end
    end
  end

  always_comb begin
    vld = 1'b1;
    unique case (sel)
      RD_LANE0: val = {{(SW-DW){res[DW-1]}}, res[DW-1:0]};
      RD_SUM:   val = sum;
      RD_IMIN:  val = any ? {{(SW-IW){1'b0}}, lo_idx} : '1;
      RD_IMAX:  val = any ? {{(SW-IW){1'b0}}, hi_idx} : '1;
      default: begin
        val = '0;
        vld = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/vec_rep_seq.sv
module vec_rep_seq
  import vrs_pkg::*;
#(
  parameter int LANES = 16,
  parameter int DW    = 16,
  parameter int CNT_W = 8,
  parameter int SW    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [2:0]          rep_code,
  input  logic [CNT_W-1:0]    rep_scalar,
  input  logic [2:0]          pred_sel,
  input  logic                set_flags,
  input  logic                clr_acc,
  input  logic                acc_en,
  input  logic                sub_mode,
  input  logic [2:0]          red_sel,
  input  logic [LANES*DW-1:0] opa,
  input  logic [LANES*DW-1:0] opb,
  output logic                busy,
  output logic                res_vld,
  output logic [LANES-1:0]    lane_we,
  output logic [LANES*DW-1:0] lane_res,
  output logic [LANES-1:0]    flag_z,
  output logic [LANES-1:0]    flag_n,
  output logic [LANES-1:0]    flag_c,
  output logic                scal_vld,
  output logic [SW-1:0]       scal_res,
  output logic                scal_n,
  output logic                scal_z,
  output logic                done
);

  localparam int RC_W = (CNT_W > 7) ? CNT_W : 7;

  cfg_t                cfg_in;
  cfg_t                cfg_q;
  logic                first;
  logic                last;
  logic [LANES*DW-1:0] res_c;
  logic [LANES-1:0]    act_c;
  logic [SW-1:0]       red_val;
  logic                red_vld;
  logic                idx_mode_q;

  assign cfg_in = '{pred: pred_sel, setf: set_flags, clr: clr_acc,
                    acc: acc_en, sub: sub_mode, red: red_sel};

  vrs_ctrl #(.CNT_W(CNT_W), .RC_W(RC_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .rep_code   (rep_code),
    .rep_scalar (rep_scalar),
    .cfg_in     (cfg_in),
    .busy       (busy),
    .first      (first),
    .last       (last),
    .cfg_q      (cfg_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vrs_lane #(.DW(DW)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .step   (busy),
      .first  (first),
      .pred   (cfg_q.pred),
      .setf   (cfg_q.setf),
      .clr    (cfg_q.clr),
      .acc_en (cfg_q.acc),
      .sub    (cfg_q.sub),
      .a      (opa[g*DW +: DW]),
      .b      (opb[g*DW +: DW]),
      .res    (res_c[g*DW +: DW]),
      .act    (act_c[g]),
      .fz     (flag_z[g]),
      .fn     (flag_n[g]),
      .fc     (flag_c[g])
    );
  end

  vrs_reduce #(.LANES(LANES), .DW(DW), .SW(SW)) u_red (
    .res (res_c),
    .act (act_c),
    .sel (cfg_q.red),
    .val (red_val),
    .vld (red_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld    <= 1'b0;
      lane_we    <= '0;
      lane_res   <= '0;
      done       <= 1'b0;
      scal_vld   <= 1'b0;
      scal_res   <= '0;
      scal_n     <= 1'b0;
      scal_z     <= 1'b0;
      idx_mode_q <= 1'b0;
    end else begin
      res_vld    <= busy;
      lane_we    <= busy ? act_c : '0;
      done       <= last;
      scal_vld   <= busy && red_vld;
      idx_mode_q <= busy && ((cfg_q.red == RD_IMIN) || (cfg_q.red == RD_IMAX));
      if (busy) lane_res <= res_c;
      if (busy && red_vld) begin
        scal_res <= red_val;
        scal_n   <= red_val[SW-1];
        scal_z   <= (red_val == '0);
      end
    end
  end

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst) done |-> (res_vld && !busy)); // R2
  AST_WE_QUIET: assert property (@(posedge clk) disable iff (rst) !res_vld |-> (lane_we == '0)); // R3
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst) (scal_vld && idx_mode_q) |-> ((scal_res == '1) || (scal_res < SW'(LANES)))); // R8
  AST_IDX_EMPTY: assert property (@(posedge clk) disable iff (rst) (scal_vld && idx_mode_q) |-> ((lane_we == '0) == (scal_res == '1))); // R8
  AST_SCAL_HOLD: assert property (@(posedge clk) disable iff (rst) !scal_vld |-> $stable({scal_n, scal_z})); // R9

endmodule

// File: tb/sim_vec_rep_seq.sv
`timescale 1ns/1ps
module sim_vec_rep_seq;

  localparam int L  = 16;
  localparam int DW = 16;
  localparam int SW = 32;

  typedef struct {
    logic [L-1:0]    we;
    logic [L*DW-1:0] res;
    logic            svld;
    logic [SW-1:0]   sres;
    logic            sn;
    logic            sz;
    logic            dn;
    logic [L-1:0]    fz;
    logic [L-1:0]    fn;
    logic [L-1:0]    fc;
    string           tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] rep_code = '0;
  logic [7:0] rep_scalar = '0;
  logic [2:0] pred_sel = '0;
  logic set_flags = 1'b0, clr_acc = 1'b0, acc_en = 1'b0, sub_mode = 1'b0;
  logic [2:0] red_sel = '0;
  logic [L*DW-1:0] opa = '0, opb = '0;
  logic busy, res_vld, scal_vld, scal_n, scal_z, done;
  logic [L-1:0] lane_we, flag_z, flag_n, flag_c;
  logic [L*DW-1:0] lane_res;
  logic [SW-1:0] scal_res;

  int n_cmp = 0;
  int n_bad = 0;
  item_t q[$];
  item_t mon_it;

  logic [L-1:0]  m_z = '0, m_n = '0, m_c = '0;
  logic [DW-1:0] m_acc [L];
  logic          m_sn = 1'b0, m_sz = 1'b0;
  logic [L*DW-1:0] va, vb;

  always #2 clk = ~clk;

  vec_rep_seq u0 (
    .clk(clk), .rst(rst), .start(start), .rep_code(rep_code), .rep_scalar(rep_scalar),
    .pred_sel(pred_sel), .set_flags(set_flags), .clr_acc(clr_acc), .acc_en(acc_en),
    .sub_mode(sub_mode), .red_sel(red_sel), .opa(opa), .opb(opb), .busy(busy),
    .res_vld(res_vld), .lane_we(lane_we), .lane_res(lane_res), .flag_z(flag_z),
    .flag_n(flag_n), .flag_c(flag_c), .scal_vld(scal_vld), .scal_res(scal_res),
    .scal_n(scal_n), .scal_z(scal_z), .done(done)
  );

  task automatic chk(input string tag, input string what, input logic [L*DW-1:0] act, input logic [L*DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per repetition result.
  always @(negedge clk) begin
    if (!rst && res_vld) begin
      if (q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R1 unexpected result: actual 1 expected 0");
      end else begin
        mon_it = q.pop_front();
        chk(mon_it.tag, "lane_we", L*DW'(lane_we), L*DW'(mon_it.we));
        chk(mon_it.tag, "lane_res", lane_res, mon_it.res);
        chk(mon_it.tag, "flags_z", L*DW'(flag_z), L*DW'(mon_it.fz));
        chk(mon_it.tag, "flags_n", L*DW'(flag_n), L*DW'(mon_it.fn));
        chk(mon_it.tag, "flags_c", L*DW'(flag_c), L*DW'(mon_it.fc));
        chk(mon_it.tag, "scal_vld", L*DW'(scal_vld), L*DW'(mon_it.svld));
        if (mon_it.svld) chk(mon_it.tag, "scal_res", L*DW'(scal_res), L*DW'(mon_it.sres));
        chk(mon_it.tag, "scal_nz", L*DW'({scal_n, scal_z}), L*DW'({mon_it.sn, mon_it.sz}));
        chk(mon_it.tag, "done", L*DW'(done), L*DW'(mon_it.dn));
      end
    end
  end

  // Driver: builds the expected items from the requirements, then launches.
  task automatic run_op(input string tag, input logic [2:0] rc, input logic [7:0] rs,
                        input logic [2:0] pr, input logic sf, input logic cl, input logic ac,
                        input logic sb, input logic [2:0] rd,
                        input logic [L*DW-1:0] a, input logic [L*DW-1:0] b, input bit poke);
    int n;
    n = (rc == 3'd7) ? ((rs == 0) ? 1 : int'(rs)) : (1 << rc);
    for (int k = 0; k < n; k++) begin
      item_t it;
      int lv [L];
      int sum;
      int bi;
      it.tag = tag;
      sum = 0;
      for (int i = 0; i < L; i++) begin
        logic [DW:0]   raw;
        logic [DW-1:0] base, sat, v;
        logic [DW:0]   s;
        logic          act;
        raw = sb ? ({1'b0, a[i*DW +: DW]} - {1'b0, b[i*DW +: DW]})
                 : ({1'b0, a[i*DW +: DW]} + {1'b0, b[i*DW +: DW]});
        case (pr)
          3'd0: act = 1'b1;
          3'd1: act = 1'b0;
          3'd2: act = m_z[i];
          3'd3: act = !m_z[i];
          3'd4: act = m_n[i];
          3'd5: act = !m_n[i];
          3'd6: act = m_c[i];
          default: act = !m_c[i];
        endcase
        base = (k == 0 && cl) ? '0 : m_acc[i];
        s = {base[DW-1], base} + {raw[DW-1], raw[DW-1:0]};
        if (s[DW] != s[DW-1]) sat = s[DW] ? 16'h8000 : 16'h7FFF;
        else sat = s[DW-1:0];
        v = ac ? sat : raw[DW-1:0];
        m_acc[i] = (act && ac) ? sat : base;
        if (act && sf) begin
          m_z[i] = (v == 0);
          m_n[i] = v[DW-1];
          m_c[i] = raw[DW];
        end
        it.res[i*DW +: DW] = v;
        it.we[i] = act;
        lv[i] = int'($signed(v));
        if (act) sum += lv[i];
      end
      it.svld = (rd >= 3'd1) && (rd <= 3'd4);
      bi = -1;
      for (int i = 0; i < L; i++) begin
        if (it.we[i]) begin
          if (bi < 0) bi = i;
          else if (rd == 3'd3 && lv[i] < lv[bi]) bi = i;
          else if (rd == 3'd4 && lv[i] > lv[bi]) bi = i;
        end
      end
      case (rd)
        3'd1: it.sres = SW'(lv[0]);
        3'd2: it.sres = SW'(sum);
        3'd3, 3'd4: it.sres = SW'(bi);
        default: it.sres = '0;
      endcase
      if (it.svld) begin
        m_sn = it.sres[SW-1];
        m_sz = (it.sres == 0);
      end
      it.sn = m_sn;
      it.sz = m_sz;
      it.dn = (k == n - 1);
      it.fz = m_z;
      it.fn = m_n;
      it.fc = m_c;
      q.push_back(it);
    end
    @(negedge clk);
    rep_code = rc; rep_scalar = rs; pred_sel = pr; set_flags = sf; clr_acc = cl;
    acc_en = ac; sub_mode = sb; red_sel = rd; opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R2: a second launch while busy, with a different instruction
      @(negedge clk);
      start = 1'b1; pred_sel = 3'd1; rep_code = 3'd0; red_sel = 3'd2; acc_en = 1'b1;
      @(negedge clk);
      start = 1'b0; pred_sel = pr; rep_code = rc; red_sel = rd; acc_en = ac;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(tag, "idle after done (R2)", L*DW'({busy, res_vld}), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < L; i++) m_acc[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10", "ctrl outputs", L*DW'({busy, res_vld, done, scal_vld, scal_n, scal_z}), '0);
    chk("R10", "lane_we", L*DW'(lane_we), '0);
    chk("R10", "flags", L*DW'({flag_z, flag_n, flag_c}), '0);

    // R4 add with carry-out, R8 sum, R1 single repetition
    for (int i = 0; i < L; i++) begin
      va[i*DW +: DW] = 16'(i * 16'h1111);
      vb[i*DW +: DW] = 16'(16'h0F00 + i);
    end
    run_op("R4", 3'd0, 8'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2, va, vb, 0);

    // R4 subtract with borrow, R5 flags, R8 lane 0, two repetitions
    for (int i = 0; i < L; i++) begin
      va[i*DW +: DW] = (i < 8) ? 16'(i * 3) : 16'h0100;
      vb[i*DW +: DW] = (i % 4 == 0) ? va[i*DW +: DW] : 16'(i * 5);
    end
    run_op("R5", 3'd1, 8'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1, va, vb, 0);

    // R3 if-zero with flags changing between repetitions, R8 index-of-min ties
    for (int i = 0; i < L; i++) begin
      va[i*DW +: DW] = (i % 4 == 0) ? 16'd0 : 16'(i);
      vb[i*DW +: DW] = (i == 4) ? 16'hFFFF : 16'd0;
    end
    run_op("R3", 3'd2, 8'd0, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3, va, vb, 0);

    // R3 never: no writes; R5 flags held despite set_flags; R8 index gives -1
    run_op("R8", 3'd0, 8'd0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd4, va, vb, 0);

    // R6 saturation both ways, R7 clear on first of 64 repetitions
    for (int i = 0; i < L; i++) begin
      va[i*DW +: DW] = (i % 2 == 1) ? 16'(-(i * 16'h0300)) : 16'(i * 16'h0400);
      vb[i*DW +: DW] = 16'd0;
    end
    run_op("R6", 3'd6, 8'd0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd2, va, vb, 0);

    // R7 accumulator continues without a new clear; if-not-negative predicate
    for (int i = 0; i < L; i++) begin
      va[i*DW +: DW] = 16'd1;
      vb[i*DW +: DW] = 16'd0;
    end
    run_op("R7", 3'd1, 8'd0, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 3'd4, va, vb, 0);

    // R1 scalar count of zero runs once; if-carry predicate
    for (int i = 0; i < L; i++) begin
      va[i*DW +: DW] = 16'(16'hF000 + i * 16'h0123);
      vb[i*DW +: DW] = 16'(i * 16'h0200);
    end
    run_op("R1", 3'd7, 8'd0, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, va, vb, 0);

    // R1 scalar count of three; R7 clear with subtracting accumulation
    run_op("R1", 3'd7, 8'd3, 3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 3'd3, va, vb, 0);

    // R9 no reduction: scalar flags held; R8 codes 0 and 7 produce nothing
    run_op("R9", 3'd0, 8'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, va, vb, 0);
    run_op("R9", 3'd1, 8'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7, va, vb, 0);

    // R8 index-of-max with all lanes equal: lowest lane wins
    for (int i = 0; i < L; i++) begin
      va[i*DW +: DW] = 16'd5;
      vb[i*DW +: DW] = 16'd0;
    end
    run_op("R8", 3'd0, 8'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, va, vb, 0);

    // R2 start pulse during an eight-repetition run is ignored
    for (int i = 0; i < L; i++) begin
      va[i*DW +: DW] = 16'(i * 16'h0777);
      vb[i*DW +: DW] = 16'(16'h0101 * (L - i));
    end
    run_op("R2", 3'd3, 8'd0, 3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 3'd4, va, vb, 1);

    repeat (3) @(negedge clk);
    chk("R2", "queue drained", L*DW'(q.size()), '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule